// File: doc/BRIEF.md
# Instruction Fetch and Next-PC Unit

This block holds the program counter of a single-cycle processor and delivers the 32-bit instruction word at that address from a small internal instruction store. The store is read combinationally, so the instruction word follows the program counter within the same cycle. The decode and compare logic downstream can use it in that cycle.

At every rising clock edge the program counter moves to its next value. Normally this is the following word, four bytes on. When the datapath asks for a branch and its equality compare holds, the counter moves to a PC-relative target instead. The target is the sequential address plus the 16-bit offset from the instruction, sign-extended and scaled to words. The offset comes in on its own input port, which the datapath wires to bits [15:0] of the fetched word.

The instruction store is a generated read-only table of `2**IDX_W` words. It has no load path. Word `i` holds a fixed tag in its upper half and the low 16 bits of `i` in its lower half, so every fetched word tells the reader which entry it came from.

Top module: `ifu_fetch_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the counter is loaded with 0, whatever the branch inputs are; `pc_o` reads 0 after that edge.
- R2: With `br_req_i` = 0 and `eq_i` = 0, each rising edge adds 4 to `pc_o`.
- R3: With `br_req_i` = 1 and `eq_i` = 1, the next `pc_o` is `pc_o + 4 + {sign-extended off_i, 2'b00}`, computed modulo 2^32.
- R4: A branch request with `eq_i` = 0 is not taken: the next `pc_o` is `pc_o + 4`.
- R5: `eq_i` = 1 without a branch request has no effect: the next `pc_o` is `pc_o + 4`.
- R6: An `off_i` with bit 15 set is a negative word offset, so the branch goes backward (0xFFFF moves to `pc_o + 4 - 4`).
- R7: `instr_o` equals the store word indexed by `pc_o[IDX_W+1:2]` in the same cycle, where word `i` is `{WORD_TAG[15:0], i[15:0]}`.
- R8: The store index is taken modulo `2**IDX_W`: a counter past the end of the store fetches the word at `(pc_o >> 2) mod 2**IDX_W`.
- R9: `pc_o[1:0]` is always 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| br_req_i | input | 1 | Current instruction is a conditional branch |
| eq_i | input | 1 | Equality result from the datapath compare |
| off_i | input | 16 | Branch word offset (instruction bits [15:0]) |
| instr_o | output | 32 | Instruction word at the current counter |
| pc_o | output | 32 | Current program counter |

## Verification
The bench builds the unit with the default `IDX_W` = 6, which gives a 64-word store, and `WORD_TAG` = 16'hC0DE. A store of that size is small enough that a single forward branch of 70 words, or the largest positive offset, moves the counter past the end of the store. The wrap of the index is therefore observable through `instr_o`.

Backward offsets of -2, -7 and -1 words take the counter back toward zero. The bench checks the counter after each of these steps. Reset is applied in the middle of a run with a taken branch asserted on the same edge, to show that reset overrides the branch.

// File: rtl/ifu_pkg.sv
package ifu_pkg;

    localparam int unsigned PC_W   = 32;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned OFF_W  = 16;
    localparam int unsigned STEP   = 4;

    typedef logic [PC_W-1:0]   pc_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [OFF_W-1:0]  off_t;

    typedef struct packed {
        pc_t pc;
    } fetch_state_t;

    typedef enum logic [1:0] {
        NXT_RESET  = 2'd0,
        NXT_SEQ    = 2'd1,
        NXT_BRANCH = 2'd2
    } nxt_src_e;

    // Sign-extend a word offset and scale it to bytes.
    function automatic pc_t scale_offset(input off_t off);
        return {{(PC_W-OFF_W-2){off[OFF_W-1]}}, off, 2'b00};
    endfunction

endpackage

// File: rtl/ifu_rom.sv
module ifu_rom
    import ifu_pkg::*;
#(
    parameter int unsigned IDX_W    = 6,
    parameter logic [15:0] WORD_TAG = 16'hC0DE
) (
    input  logic [IDX_W-1:0] idx_i,
    output word_t            word_o
);
    localparam int unsigned DEPTH = 1 << IDX_W;
    localparam int unsigned LOW_W = WORD_W - 16;

    word_t tbl [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        localparam logic [LOW_W-1:0] ENTRY_ID = LOW_W'(g);
        assign tbl[g] = {WORD_TAG, ENTRY_ID};
    end

    assign word_o = tbl[idx_i];

endmodule

// File: rtl/ifu_next_pc.sv
module ifu_next_pc
    import ifu_pkg::*;
(
    input  pc_t      pc_i,
    input  logic     br_req_i,
    input  logic     eq_i,
    input  off_t     off_i,
    output pc_t      pc_seq_o,
    output pc_t      pc_tgt_o,
    output logic     take_o
);
    pc_t seq;
    pc_t tgt;

    always_comb begin
        seq      = pc_i + pc_t'(STEP);
        tgt      = seq + scale_offset(off_i);
        pc_seq_o = seq;
        pc_tgt_o = tgt;
        take_o   = br_req_i & eq_i;
    end

endmodule

// File: rtl/ifu_fetch_unit.sv
module ifu_fetch_unit
    import ifu_pkg::*;
#(
    parameter int unsigned IDX_W    = 6,
    parameter logic [15:0] WORD_TAG = 16'hC0DE
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        br_req_i,
    input  logic        eq_i,
    input  logic [15:0] off_i,
    output logic [31:0] instr_o,
    output logic [31:0] pc_o
);
    localparam int unsigned IDX_LO = 2;
    localparam int unsigned IDX_HI = IDX_W + IDX_LO - 1;

    fetch_state_t st_d, st_q;
    pc_t          pc_seq, pc_tgt;
    logic         take;
    nxt_src_e     src;
    word_t        rom_word;

    ifu_next_pc u_next (
        .pc_i     (st_q.pc),
        .br_req_i (br_req_i),
        .eq_i     (eq_i),
        .off_i    (off_i),
        .pc_seq_o (pc_seq),
        .pc_tgt_o (pc_tgt),
        .take_o   (take)
    );

    ifu_rom #(
        .IDX_W    (IDX_W),
        .WORD_TAG (WORD_TAG)
    ) u_rom (
        .idx_i  (st_q.pc[IDX_HI:IDX_LO]),
        .word_o (rom_word)
    );

    always_comb begin
        st_d = st_q;
        if (rst)       src = NXT_RESET;
        else if (take) src = NXT_BRANCH;
        else           src = NXT_SEQ;
        unique case (src)
            NXT_RESET:  st_d.pc = '0;
            NXT_BRANCH: st_d.pc = pc_tgt;
            default:    st_d.pc = pc_seq;
        endcase
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pc_o    = st_q.pc;
    assign instr_o = rom_word;

endmodule

// File: rtl/ifu_fetch_unit_chk.sv
module ifu_fetch_unit_chk #(
    parameter int unsigned IDX_W    = 6,
    parameter logic [15:0] WORD_TAG = 16'hC0DE
) (
    input logic        clk,
    input logic        rst,
    input logic        br_req_i,
    input logic        eq_i,
    input logic [15:0] off_i,
    input logic [31:0] instr_o,
    input logic [31:0] pc_o
);
    logic rst_prev_q;

    always_ff @(posedge clk) begin
        rst_prev_q <= rst;
    end

    always_ff @(posedge clk) begin
        if (rst_prev_q) begin
            AST_RESET_ZERO: assert (pc_o == 32'd0); // R1
        end
    end

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        !(br_req_i && eq_i) |=> pc_o == $past(pc_o) + 32'd4); // R2

    AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (rst)
        (br_req_i && eq_i) |=>
        pc_o == $past(pc_o) + 32'd4 + {{14{$past(off_i[15])}}, $past(off_i), 2'b00}); // R3

    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (rst)
        rst_prev_q |-> pc_o[1:0] == 2'b00); // R9

    AST_FETCH_WORD: assert property (@(posedge clk) disable iff (rst)
        rst_prev_q |-> instr_o == {WORD_TAG, 16'(pc_o[IDX_W+1:2])}); // R7

endmodule

bind ifu_fetch_unit ifu_fetch_unit_chk #(
    .IDX_W    (IDX_W),
    .WORD_TAG (WORD_TAG)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .br_req_i (br_req_i),
    .eq_i     (eq_i),
    .off_i    (off_i),
    .instr_o  (instr_o),
    .pc_o     (pc_o)
);

// File: tb/ifu_fetch_unit_tb.sv
module ifu_fetch_unit_tb;

    localparam int unsigned IDX_W    = 6;
    localparam logic [15:0] WORD_TAG = 16'hC0DE;
    localparam int unsigned NVEC     = 9;

    // {br_req, eq, off, expected pc after the edge}
    typedef struct packed {
        logic        br;
        logic        eq;
        logic [15:0] off;
        logic [31:0] pc;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 16'd0,    32'd4},   // R2
        '{1'b1, 1'b1, 16'd3,    32'd20},  // R3
        '{1'b1, 1'b0, 16'd100,  32'd24},  // R4
        '{1'b0, 1'b1, 16'd100,  32'd28},  // R5
        '{1'b1, 1'b1, 16'hFFFE, 32'd24},  // R6
        '{1'b1, 1'b1, 16'hFFF9, 32'd0},   // R6
        '{1'b1, 1'b1, 16'd70,   32'd284}, // R3, R8
        '{1'b0, 1'b0, 16'd0,    32'd288}, // R2, R8
        '{1'b1, 1'b1, 16'hFFFF, 32'd288}  // R6
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        br_req_i;
    logic        eq_i;
    logic [15:0] off_i;
    logic [31:0] instr_o;
    logic [31:0] pc_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    ifu_fetch_unit #(
        .IDX_W    (IDX_W),
        .WORD_TAG (WORD_TAG)
    ) u_dut (
        .clk      (clk),
        .rst      (rst),
        .br_req_i (br_req_i),
        .eq_i     (eq_i),
        .off_i    (off_i),
        .instr_o  (instr_o),
        .pc_o     (pc_o)
    );

    function automatic logic [31:0] exp_word(input logic [31:0] pc);
        logic [31:0] idx;
        idx = (pc >> 2) % (32'd1 << IDX_W);
        return {WORD_TAG, idx[15:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic br, input logic eq, input logic [15:0] off);
        br_req_i = br;
        eq_i     = eq;
        off_i    = off;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        rst      = 1'b1;
        br_req_i = 1'b0;
        eq_i     = 1'b0;
        off_i    = '0;
        @(negedge clk);
        step(1'b0, 1'b0, 16'd0);
        check("R1 pc after reset", pc_o, 32'd0);
        check("R7 word at reset", instr_o, exp_word(32'd0));
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            step(VECS[i].br, VECS[i].eq, VECS[i].off);
            check($sformatf("R2-R6 vec %0d pc", i), pc_o, VECS[i].pc);
            check($sformatf("R7/R8 vec %0d word", i), instr_o, exp_word(VECS[i].pc));
        end

        // R8: index wraps past the end of the store
        check("R8 wrapped index", {16'd0, instr_o[15:0]}, 32'd8);

        // R1: reset overrides a taken branch
        rst = 1'b1;
        step(1'b1, 1'b1, 16'd50);
        check("R1 reset over branch", pc_o, 32'd0);
        rst = 1'b0;

        // R3/R8: largest positive offset
        step(1'b1, 1'b1, 16'h7FFF);
        check("R3 max forward pc", pc_o, 32'd131072);
        check("R8 max forward word", instr_o, {WORD_TAG, 16'd0});

        // R9: alignment kept after branches
        check("R9 alignment", {30'd0, pc_o[1:0]}, 32'd0);

        // R4 with negative offset: still sequential
        step(1'b1, 1'b0, 16'h8000);
        check("R4 not taken negative", pc_o, 32'd131076);
        check("R7 word after step", instr_o, exp_word(32'd131076));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule